// File: doc/BRIEF.md
# One-Bit Global Coherence Directory

This block sits beside the memory controller and resolves coherence requests that a home directory inside a tile group could not satisfy. It keeps one presence bit per block instead of a list of sharers. When the bit is clear, no tile holds any of the block's tokens. When it is set, some tile holds all of them.

A level-two read to a block whose bit is clear is granted straight from memory, and the bit is set. A level-two read to a block whose bit is set is recorded in a small pending table and sent to every tile as a broadcast. Both kinds of read leave the block blocked. The requester sends a completion message once it has its data, and that message releases the block. Any request that arrives for a blocked block waits at the request port until the release.

A writeback that returns all tokens to memory clears the bit. Requests whose level bit marks them as first-level do not belong to this block and are dropped.

Top module: `onebit_gdir`

## Requirements
- R1: After reset every presence bit is clear, the pending table is empty, `rsp_valid_o` and `bc_valid_o` are low, and a level-two read to any block is accepted (`req_ready_o` high).
- R2: An accepted level-two read (`req_lvl2_i`=1, `req_wb_i`=0) to a block whose bit is clear raises `rsp_valid_o` in the cycle after acceptance, carrying that block and requesting tile. The bit is then set.
- R3: An accepted level-two read to a block whose bit is set raises `bc_valid_o` in the cycle after acceptance, with the block, the requester, `bc_mask_o` all ones and `bc_lvl2_o`=1. No data response is raised.
- R4: Once a level-two read is accepted, its block is blocked. Further level-two requests to that block, reads or writebacks, see `req_ready_o` low. A completion (`cmp_valid_i` with that block) seen at a clock edge releases the block from that edge on.
- R5: A completion naming a block that has no pending entry has no effect.
- R6: An accepted level-two writeback (`req_wb_i`=1) to a block that is not blocked clears its bit. It produces no response or broadcast, so a following read to that block is answered with data.
- R7: A request with `req_lvl2_i`=0 is always accepted and then discarded. It produces no output and changes no bit.
- R8: The pending table holds `PEND_DEPTH` reads. While it is full, reads to other blocks are refused, but writebacks to unblocked blocks are still accepted.
- R9: A raised response or broadcast keeps its valid and payload until its ready is high at a clock edge. At most one of the two is valid at a time, and no read is accepted while either is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted at this edge |
| req_lvl2_i | input | 1 | 1 = second-level request, 0 = first-level |
| req_wb_i | input | 1 | 1 = writeback returning all tokens, 0 = read |
| req_blk_i | input | BLK_W | Block index |
| req_tile_i | input | TILE_W | Requesting tile |
| cmp_valid_i | input | 1 | Completion message valid |
| cmp_blk_i | input | BLK_W | Block being released |
| rsp_valid_o | output | 1 | Data grant from memory valid |
| rsp_ready_i | input | 1 | Data grant taken |
| rsp_blk_o | output | BLK_W | Granted block |
| rsp_tile_o | output | TILE_W | Tile receiving the data |
| bc_valid_o | output | 1 | Broadcast valid |
| bc_ready_i | input | 1 | Broadcast taken by the fabric |
| bc_mask_o | output | NUM_TILES | Destination tiles |
| bc_blk_o | output | BLK_W | Broadcast block |
| bc_tile_o | output | TILE_W | Original requester |
| bc_lvl2_o | output | 1 | Level bit of the broadcast message |

## Verification
The assertions assume three things about the environment. A sender holds a request's fields steady while `req_valid_i` is high and `req_ready_o` is low. At most one completion arrives per cycle. The output consumers never see a new message replace one they have not taken.

The bench drives each request from the falling edge and drops it after one accepting edge or one refused look. It issues completions mostly for blocks its own model holds as pending, with a few deliberately stray ones. Random requests are confined to eight blocks so that blocked, full and cached cases all occur often.

// File: rtl/onebit_gdir_pkg.sv
package onebit_gdir_pkg;
  typedef enum logic [1:0] {
    CMD_DROP = 2'd0,
    CMD_READ = 2'd1,
    CMD_WB   = 2'd2
  } gdir_cmd_e;
endpackage

// File: rtl/onebit_gdir_presence.sv
module onebit_gdir_presence #(
  parameter int NUM_BLKS = 256,
  localparam int BLK_W = $clog2(NUM_BLKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BLK_W-1:0] addr_i,
  input  logic             set_i,
  input  logic             clr_i,
  output logic             bit_o
);
  logic [NUM_BLKS-1:0] bits_q;

  assign bit_o = bits_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bits_q <= '0;
    else if (set_i) bits_q[addr_i] <= 1'b1;
    else if (clr_i) bits_q[addr_i] <= 1'b0;
  end

  // R6
  set_clr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i && clr_i));
endmodule

// File: rtl/onebit_gdir_pend.sv
module onebit_gdir_pend #(
  parameter int NUM_BLKS   = 256,
  parameter int PEND_DEPTH = 4,
  localparam int BLK_W  = $clog2(NUM_BLKS),
  localparam int SLOT_W = (PEND_DEPTH > 1) ? $clog2(PEND_DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BLK_W-1:0] lookup_blk_i,
  output logic             hit_o,
  output logic             full_o,
  input  logic             alloc_i,
  input  logic [BLK_W-1:0] alloc_blk_i,
  input  logic             free_i,
  input  logic [BLK_W-1:0] free_blk_i
);
  logic [PEND_DEPTH-1:0] valid_q, hit_vec, free_vec;
  logic [BLK_W-1:0]      blk_q [PEND_DEPTH];
  logic [SLOT_W-1:0]     slot;
  logic                  found;

  for (genvar g = 0; g < PEND_DEPTH; g++) begin : g_cmp
    assign hit_vec[g]  = valid_q[g] && (blk_q[g] == lookup_blk_i);
    assign free_vec[g] = free_i && valid_q[g] && (blk_q[g] == free_blk_i);
  end

  assign hit_o  = |hit_vec;
  assign full_o = &valid_q;

  // lowest free slot
  always_comb begin
    slot  = '0;
    found = 1'b0;
    for (int i = 0; i < PEND_DEPTH; i++) begin
      if (!found && !valid_q[i]) begin
        slot  = i[SLOT_W-1:0];
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < PEND_DEPTH; i++) blk_q[i] <= '0;
    end else begin
      for (int i = 0; i < PEND_DEPTH; i++)
        if (free_vec[i]) valid_q[i] <= 1'b0;
      if (alloc_i && found) begin
        valid_q[slot] <= 1'b1;
        blk_q[slot]   <= alloc_blk_i;
      end
    end
  end

  // R8
  alloc_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !full_o);
  // R4
  alloc_unblocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !hit_o);
  // R4
  single_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/onebit_gdir.sv
module onebit_gdir
  import onebit_gdir_pkg::*;
#(
  parameter int NUM_TILES  = 64,
  parameter int NUM_BLKS   = 256,
  parameter int PEND_DEPTH = 4,
  localparam int BLK_W  = $clog2(NUM_BLKS),
  localparam int TILE_W = $clog2(NUM_TILES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_lvl2_i,
  input  logic                 req_wb_i,
  input  logic [BLK_W-1:0]     req_blk_i,
  input  logic [TILE_W-1:0]    req_tile_i,
  input  logic                 cmp_valid_i,
  input  logic [BLK_W-1:0]     cmp_blk_i,
  output logic                 rsp_valid_o,
  input  logic                 rsp_ready_i,
  output logic [BLK_W-1:0]     rsp_blk_o,
  output logic [TILE_W-1:0]    rsp_tile_o,
  output logic                 bc_valid_o,
  input  logic                 bc_ready_i,
  output logic [NUM_TILES-1:0] bc_mask_o,
  output logic [BLK_W-1:0]     bc_blk_o,
  output logic [TILE_W-1:0]    bc_tile_o,
  output logic                 bc_lvl2_o
);
  gdir_cmd_e cmd;
  logic      blocked, full, present, out_busy;
  logic      fire, rd_fire, wb_fire;

  assign cmd = !req_lvl2_i ? CMD_DROP : (req_wb_i ? CMD_WB : CMD_READ);
  assign out_busy = rsp_valid_o | bc_valid_o;

  always_comb begin
    unique case (cmd)
      CMD_READ: req_ready_o = !blocked && !full && !out_busy;
      CMD_WB:   req_ready_o = !blocked;
      default:  req_ready_o = 1'b1;
    endcase
  end

  assign fire    = req_valid_i && req_ready_o;
  assign rd_fire = fire && (cmd == CMD_READ);
  assign wb_fire = fire && (cmd == CMD_WB);

  onebit_gdir_presence #(.NUM_BLKS(NUM_BLKS)) u_presence (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (req_blk_i),
    .set_i  (rd_fire && !present),
    .clr_i  (wb_fire),
    .bit_o  (present)
  );

  onebit_gdir_pend #(.NUM_BLKS(NUM_BLKS), .PEND_DEPTH(PEND_DEPTH)) u_pend (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lookup_blk_i (req_blk_i),
    .hit_o        (blocked),
    .full_o       (full),
    .alloc_i      (rd_fire),
    .alloc_blk_i  (req_blk_i),
    .free_i       (cmp_valid_i),
    .free_blk_i   (cmp_blk_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_blk_o   <= '0;
      rsp_tile_o  <= '0;
      bc_valid_o  <= 1'b0;
      bc_blk_o    <= '0;
      bc_tile_o   <= '0;
    end else begin
      if (rd_fire && !present) begin
        rsp_valid_o <= 1'b1;
        rsp_blk_o   <= req_blk_i;
        rsp_tile_o  <= req_tile_i;
      end else if (rsp_ready_i) begin
        rsp_valid_o <= 1'b0;
      end
      if (rd_fire && present) begin
        bc_valid_o <= 1'b1;
        bc_blk_o   <= req_blk_i;
        bc_tile_o  <= req_tile_i;
      end else if (bc_ready_i) begin
        bc_valid_o <= 1'b0;
      end
    end
  end

  assign bc_mask_o = '1;
  assign bc_lvl2_o = 1'b1;

  // R9
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_blk_o) && $stable(rsp_tile_o));
  // R9
  bc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_valid_o && !bc_ready_i |=> bc_valid_o && $stable(bc_blk_o) && $stable(bc_tile_o));
  // R9
  one_msg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rsp_valid_o, bc_valid_o}));
endmodule

// File: tb/onebit_gdir_tb_top.sv
`timescale 1ns/1ps
module onebit_gdir_tb_top;
  localparam int NUM_TILES  = 64;
  localparam int NUM_BLKS   = 256;
  localparam int PEND_DEPTH = 4;
  localparam int BLK_W  = $clog2(NUM_BLKS);
  localparam int TILE_W = $clog2(NUM_TILES);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_lvl2_i = 1'b0, req_wb_i = 1'b0;
  logic [BLK_W-1:0] req_blk_i = '0, cmp_blk_i = '0;
  logic [TILE_W-1:0] req_tile_i = '0;
  logic cmp_valid_i = 1'b0, rsp_ready_i = 1'b1, bc_ready_i = 1'b1;
  logic req_ready_o, rsp_valid_o, bc_valid_o, bc_lvl2_o;
  logic [BLK_W-1:0] rsp_blk_o, bc_blk_o;
  logic [TILE_W-1:0] rsp_tile_o, bc_tile_o;
  logic [NUM_TILES-1:0] bc_mask_o;

  always #2 clk_i = ~clk_i;

  onebit_gdir #(.NUM_TILES(NUM_TILES), .NUM_BLKS(NUM_BLKS), .PEND_DEPTH(PEND_DEPTH)) dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_lvl2_i, .req_wb_i, .req_blk_i,
    .req_tile_i, .cmp_valid_i, .cmp_blk_i, .rsp_valid_o, .rsp_ready_i, .rsp_blk_o,
    .rsp_tile_o, .bc_valid_o, .bc_ready_i, .bc_mask_o, .bc_blk_o, .bc_tile_o, .bc_lvl2_o
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit ref_bit [NUM_BLKS];
  bit ref_pend [NUM_BLKS];
  int pend_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ready(input bit lvl, input bit wb, input int blk);
    if (!lvl) return 1'b1;
    if (ref_pend[blk]) return 1'b0;
    if (wb) return 1'b1;
    return pend_cnt < PEND_DEPTH;
  endfunction

  task automatic do_req(input bit lvl, input bit wb, input int blk, input int tile,
                        input string tag);
    bit er, was_set, is_rd;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_lvl2_i = lvl; req_wb_i = wb;
    req_blk_i = blk[BLK_W-1:0]; req_tile_i = tile[TILE_W-1:0];
    #1;
    er = exp_ready(lvl, wb, blk);
    chk(req_ready_o == er, tag, "ready", req_ready_o, er);
    if (!er) begin
      req_valid_i = 1'b0;
      return;
    end
    is_rd = lvl && !wb;
    was_set = ref_bit[blk];
    if (lvl && wb) ref_bit[blk] = 1'b0;
    if (is_rd) begin
      ref_bit[blk] = 1'b1; ref_pend[blk] = 1'b1; pend_cnt++;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(rsp_valid_o == (is_rd && !was_set), tag, "rsp_valid", rsp_valid_o, is_rd && !was_set);
    chk(bc_valid_o == (is_rd && was_set), tag, "bc_valid", bc_valid_o, is_rd && was_set);
    if (is_rd && !was_set) begin
      chk(rsp_blk_o == blk[BLK_W-1:0], tag, "rsp_blk", rsp_blk_o, blk);
      chk(rsp_tile_o == tile[TILE_W-1:0], tag, "rsp_tile", rsp_tile_o, tile);
    end
    if (is_rd && was_set) begin
      chk(bc_blk_o == blk[BLK_W-1:0], tag, "bc_blk", bc_blk_o, blk);
      chk(bc_tile_o == tile[TILE_W-1:0], tag, "bc_tile", bc_tile_o, tile);
      chk(bc_mask_o == {NUM_TILES{1'b1}}, tag, "bc_mask", bc_mask_o, {NUM_TILES{1'b1}});
      chk(bc_lvl2_o == 1'b1, tag, "bc_lvl2", bc_lvl2_o, 1);
    end
    @(posedge clk_i);
  endtask

  task automatic do_cmp(input int blk);
    @(negedge clk_i);
    cmp_valid_i = 1'b1; cmp_blk_i = blk[BLK_W-1:0];
    @(posedge clk_i);
    #1 cmp_valid_i = 1'b0;
    if (ref_pend[blk]) begin
      ref_pend[blk] = 1'b0; pend_cnt--;
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(rsp_valid_o == 1'b0, "R1", "rsp_valid", rsp_valid_o, 0);
    chk(bc_valid_o == 1'b0, "R1", "bc_valid", bc_valid_o, 0);
    // R2 idle block grant, R1 first read accepted
    do_req(1, 0, 10, 3, "R2");
    // R4 blocked until completion
    do_req(1, 0, 10, 4, "R4");
    do_req(1, 1, 10, 4, "R4");
    do_cmp(10);
    // R3 cached block broadcast
    do_req(1, 0, 10, 5, "R3");
    do_cmp(10);
    // R5 stray completion leaves block 20 blocked
    do_req(1, 0, 20, 1, "R2");
    do_cmp(21);
    do_req(1, 0, 20, 2, "R5");
    do_cmp(20);
    // R6 writeback clears bit
    do_req(1, 1, 20, 7, "R6");
    do_req(1, 0, 20, 8, "R6");
    do_cmp(20);
    // R7 first-level requests discarded
    do_req(0, 0, 30, 9, "R7");
    do_req(1, 0, 30, 9, "R7");
    do_cmp(30);
    do_req(0, 1, 10, 9, "R7");
    do_req(1, 0, 10, 9, "R7");
    do_cmp(10);
    // R8 full table
    for (int b = 40; b < 40 + PEND_DEPTH; b++) do_req(1, 0, b, b, "R8");
    do_req(1, 0, 60, 2, "R8");
    do_req(1, 1, 61, 2, "R8");
    do_cmp(41);
    do_req(1, 0, 60, 2, "R8");
    for (int b = 40; b < 40 + PEND_DEPTH; b++) do_cmp(b);
    do_cmp(60);
    // R9 held response blocks new reads
    rsp_ready_i = 1'b0;
    do_req(1, 0, 70, 11, "R9");
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b1, "R9", "rsp_valid held", rsp_valid_o, 1);
    chk(rsp_blk_o == 8'd70, "R9", "rsp_blk held", rsp_blk_o, 70);
    req_valid_i = 1'b1; req_lvl2_i = 1'b1; req_wb_i = 1'b0; req_blk_i = 8'd71;
    #1;
    chk(req_ready_o == 1'b0, "R9", "ready while held", req_ready_o, 0);
    req_valid_i = 1'b0;
    rsp_ready_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R9", "rsp released", rsp_valid_o, 0);
    do_cmp(70);
    // random mix over a narrow block range
    for (int it = 0; it < 800; it++) begin
      int r, blk, tile;
      r = $urandom % 10;
      blk = 100 + ($urandom % 8);
      tile = $urandom % NUM_TILES;
      if (r < 3) do_cmp(blk);
      else if (r == 3) do_req(1, 1, blk, tile, "R6");
      else if (r == 4) do_req(0, $urandom % 2, blk, tile, "R7");
      else do_req(1, 0, blk, tile, "R4");
    end
    for (int b = 100; b < 108; b++) do_cmp(b);
    repeat (2) @(posedge clk_i);
    report();
  end
endmodule